// File: doc/BRIEF.md
# Interrupting Down-Counter Timer

This block is a single-register countdown timer. One 32-bit control word carries a 20-bit count, a run enable, an interrupt enable and a write-only acknowledge strobe. Software writes a start value with the run bit set. The counter then drops by one on every cycle in which the external tick enable is high. It stops when it reaches zero.

The step from one to zero is the only event that can raise the interrupt, and only while the interrupt enable is set. The interrupt stays pending until software writes the word with the acknowledge bit set. That acknowledge write leaves the count and both enables alone. The pending flag drives the interrupt line and also one fixed bit of a shared interrupt status word. Software can read the register at any time to see the live count.

Top module: `timer_irq_top`

## Requirements
- R1: After reset the count is 0, both enables are 0, `irq` is 0 and `stat_word` is 0.
- R2: A write with bit 26 clear is a load write. From the next clock edge, bits 19:0 become the count, bit 24 becomes the run enable and bit 25 becomes the interrupt enable. A load write wins over a tick in the same cycle.
- R3: While the run enable is 1, the count falls by exactly one on each clock edge where `tick` is 1. The count does not change when `tick` is 0 or the run enable is 0.
- R4: A count of zero holds at zero under further ticks and never wraps.
- R5: The pending flag is set on the edge where a tick moves the count from 1 to 0 with the interrupt enable at 1. It is not set when the interrupt enable is 0, when 0 is loaded, or while the count stays at 0.
- R6: A write with bit 26 set is an acknowledge write. It clears the pending flag and leaves the count and both enables unchanged. If a 1-to-0 step with the interrupt enable set happens on the same edge, the flag stays set.
- R7: `irq` equals the pending flag. Bit 5 of the 16-bit `stat_word` equals the pending flag, and every other bit of `stat_word` is 0. A load write does not clear the pending flag.
- R8: `rd_data` returns the live count in bits 19:0, the run enable in bit 24 and the interrupt enable in bit 25. Every other bit reads 0, including bit 26.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| tick | input | 1 | Prescaled count enable |
| rd_data | output | 32 | Register readback |
| irq | output | 1 | Timer interrupt (pending flag) |
| stat_word | output | 16 | Timer contribution to the shared interrupt status word |

## Verification
A table of load values and tick bursts drives the counter in four ways. A short run that stops before zero shows plain decrement. A run that lands exactly on zero, and one that overshoots, separate the single 1-to-0 event from a wrapping or re-firing counter. The same landing with the interrupt enable cleared, and a start at the 20-bit maximum, check gating and field width. Directed cases cover three races: a load and a tick on one edge, an acknowledge and an expiry on one edge, and an acknowledge carrying a non-zero value field. They also check the readback masking of undefined bits and that a load of zero raises no interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      WR_NONE = 2'd0,
      WR_LOAD = 2'd1,
      WR_ACK  = 2'd2
   } wr_kind_e;
endpackage

// File: rtl/tmr_wr_decode.sv
module tmr_wr_decode
   import tmr_pkg::*;
#(
   parameter int REG_W   = 32,
   parameter int CNT_W   = 20,
   parameter int EN_BIT  = 24,
   parameter int IEN_BIT = 25,
   parameter int ACK_BIT = 26
) (
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output wr_kind_e         kind,
   output logic [CNT_W-1:0] load_val,
   output logic             load_run,
   output logic             load_ien
);
   logic unused_bits;
   assign unused_bits = ^wr_data;

   always_comb begin
      if (!wr_en)                kind = WR_NONE;
      else if (wr_data[ACK_BIT]) kind = WR_ACK;
      else                       kind = WR_LOAD;
   end

   assign load_val = wr_data[CNT_W-1:0];
   assign load_run = wr_data[EN_BIT];
   assign load_ien = wr_data[IEN_BIT];
endmodule

// File: rtl/tmr_enable_reg.sv
module tmr_enable_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic load_run,
   input  logic load_ien,
   output logic run_en,
   output logic irq_en
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_en <= 1'b0;
         irq_en <= 1'b0;
      end else if (load) begin
         run_en <= load_run;
         irq_en <= load_ien;
      end
   end

   a_r2_enables_follow_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (run_en == $past(load_run)) && (irq_en == $past(load_ien)));
endmodule

// File: rtl/tmr_down_counter.sv
module tmr_down_counter #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] count,
   output logic             hit_zero
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic nonzero;
   assign nonzero  = |count;
   assign hit_zero = step && !load && (count == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n)              count <= '0;
      else if (load)           count <= load_val;
      else if (step && nonzero) count <= count - ONE;
   end

   a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !load) |=> (count == '0));
   a_r3_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !load) |=> $stable(count));
endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   output logic pending
);
   always_ff @(posedge clk) begin
      if (!rst_n)   pending <= 1'b0;
      else if (set) pending <= 1'b1;
      else if (ack) pending <= 1'b0;
   end

   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !set) |=> !pending);
endmodule

// File: rtl/timer_irq_top.sv
module timer_irq_top
   import tmr_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int CNT_W    = 20,
   parameter int EN_BIT   = 24,
   parameter int IEN_BIT  = 25,
   parameter int ACK_BIT  = 26,
   parameter int STAT_W   = 16,
   parameter int STAT_BIT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              tick,
   output logic [REG_W-1:0]  rd_data,
   output logic              irq,
   output logic [STAT_W-1:0] stat_word
);
   if (CNT_W < 1 || CNT_W > EN_BIT) begin : g_bad_cnt
      $error("CNT_W must fit below the control bits");
   end
   if (EN_BIT == IEN_BIT || EN_BIT == ACK_BIT || IEN_BIT == ACK_BIT) begin : g_bad_bits
      $error("control bit positions must differ");
   end
   if (ACK_BIT >= REG_W || IEN_BIT >= REG_W || EN_BIT >= REG_W) begin : g_bad_w
      $error("control bits must lie inside the register");
   end
   if (STAT_BIT >= STAT_W) begin : g_bad_stat
      $error("STAT_BIT outside the status word");
   end

   wr_kind_e         kind;
   logic [CNT_W-1:0] load_val;
   logic             load_run, load_ien;
   logic             run_en, irq_en;
   logic [CNT_W-1:0] count;
   logic             hit_zero, pending;
   logic             do_load, do_ack, step;

   tmr_wr_decode #(
      .REG_W(REG_W), .CNT_W(CNT_W), .EN_BIT(EN_BIT),
      .IEN_BIT(IEN_BIT), .ACK_BIT(ACK_BIT)
   ) u_dec (
      .wr_en(wr_en), .wr_data(wr_data), .kind(kind),
      .load_val(load_val), .load_run(load_run), .load_ien(load_ien)
   );

   assign do_load = (kind == WR_LOAD);
   assign do_ack  = (kind == WR_ACK);
   assign step    = run_en && tick;

   tmr_enable_reg u_en (
      .clk(clk), .rst_n(rst_n), .load(do_load),
      .load_run(load_run), .load_ien(load_ien),
      .run_en(run_en), .irq_en(irq_en)
   );

   tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(do_load), .load_val(load_val),
      .step(step), .count(count), .hit_zero(hit_zero)
   );

   tmr_irq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(hit_zero && irq_en),
      .ack(do_ack), .pending(pending)
   );

   assign irq = pending;

   for (genvar i = 0; i < REG_W; i++) begin : g_rd
      if (i < CNT_W) begin : g_cnt
         assign rd_data[i] = count[i];
      end else if (i == EN_BIT) begin : g_run
         assign rd_data[i] = run_en;
      end else if (i == IEN_BIT) begin : g_ien
         assign rd_data[i] = irq_en;
      end else begin : g_zero
         assign rd_data[i] = 1'b0;
      end
   end

   for (genvar j = 0; j < STAT_W; j++) begin : g_stat
      if (j == STAT_BIT) begin : g_live
         assign stat_word[j] = pending;
      end else begin : g_tie
         assign stat_word[j] = 1'b0;
      end
   end

   a_r5_rise_from_one: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> ($past(count) == CNT_W'(1)) && (count == '0));
   a_r6_ack_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
      (do_ack && !step) |=> $stable(count) && $stable(run_en) && $stable(irq_en));
endmodule

// File: tb/sim_timer_irq_top.sv
module sim_timer_irq_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        tick = 1'b0;
   logic [31:0] rd_data;
   logic        irq;
   logic [15:0] stat_word;

   int checks = 0;
   int fails  = 0;

   localparam logic [31:0] RUN = 32'h0100_0000;
   localparam logic [31:0] IEN = 32'h0200_0000;
   localparam logic [31:0] ACK = 32'h0400_0000;

   typedef struct packed {
      logic [19:0] val;
      logic [7:0]  nticks;
      logic        ien;
      logic [19:0] exp_cnt;
      logic        exp_irq;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{20'd5,     8'd3, 1'b1, 20'd2,     1'b0},
      '{20'd5,     8'd5, 1'b1, 20'd0,     1'b1},
      '{20'd5,     8'd8, 1'b1, 20'd0,     1'b1},
      '{20'd3,     8'd3, 1'b0, 20'd0,     1'b0},
      '{20'hFFFFF, 8'd4, 1'b1, 20'hFFFFB, 1'b0},
      '{20'd1,     8'd1, 1'b1, 20'd0,     1'b1}
   };

   timer_irq_top u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .tick(tick), .rd_data(rd_data), .irq(irq), .stat_word(stat_word)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         tick = 1'b1;
         repeat (n) @(negedge clk);
         tick = 1'b0;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 rd_data", rd_data, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 stat_word", {16'b0, stat_word}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R4 R5 table of runs
      for (int k = 0; k < 6; k++) begin
         wr(ACK);
         wr(RUN | (VEC[k].ien ? IEN : 32'h0) | {12'b0, VEC[k].val});
         ticks(int'(VEC[k].nticks));
         chk("R3 R4 table count", {12'b0, rd_data[19:0]}, {12'b0, VEC[k].exp_cnt});
         chk("R5 table irq", {31'b0, irq}, {31'b0, VEC[k].exp_irq});
      end

      // R7 status bit while pending
      chk("R7 stat_word", {16'b0, stat_word}, 32'h0000_0020);

      // R2 run enable clear: no counting
      wr(ACK);
      wr(32'd10);
      ticks(4);
      chk("R3 disabled count", rd_data, 32'd10);
      // R3 no tick: no counting
      wr(RUN | 32'd10);
      repeat (5) @(negedge clk);
      chk("R3 no tick", rd_data, RUN | 32'd10);

      // R2 load beats simultaneous tick
      @(negedge clk);
      wr_en = 1'b1; wr_data = RUN | 32'd40; tick = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; tick = 1'b0;
      chk("R2 load priority", rd_data, RUN | 32'd40);

      // R8 readback masks undefined bits
      wr(32'hF3F0_0ABC);
      chk("R8 readback", rd_data, 32'h0300_0ABC);

      // R5 load zero raises nothing
      wr(ACK);
      wr(RUN | IEN);
      ticks(3);
      chk("R5 zero load irq", {31'b0, irq}, 32'h0);

      // R6 R7 ack leaves count, load keeps pending
      wr(RUN | IEN | 32'd2);
      ticks(2);
      chk("R5 expire irq", {31'b0, irq}, 32'h1);
      wr(RUN | IEN | 32'd7);
      chk("R7 load keeps pending", {31'b0, irq}, 32'h1);
      ticks(2);
      wr(ACK | 32'h123);
      chk("R6 ack clears", {31'b0, irq}, 32'h0);
      chk("R6 ack keeps count", rd_data, RUN | IEN | 32'd5);
      chk("R7 stat cleared", {16'b0, stat_word}, 32'h0);

      // R6 set beats ack on the same edge
      wr(RUN | IEN | 32'd1);
      ticks(1);
      wr(RUN | IEN | 32'd1);
      @(negedge clk);
      wr_en = 1'b1; wr_data = ACK; tick = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0; tick = 1'b0;
      chk("R6 set wins irq", {31'b0, irq}, 32'h1);
      chk("R6 set wins count", rd_data, RUN | IEN);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule